// File: doc/BRIEF.md
# Memory Port Burst Self-Test Master

This block is a user-side master for one port of a memory controller that exposes three FIFOs: a command queue, a write-data queue and a read-data queue. It stays idle until the controller reports that calibration is complete. A trigger pulse then starts a self-test run. The block loads a full burst of incrementing data words into the write-data queue. It pushes a write command, then a read command to the same byte address. Finally it drains the returned words and compares each one with the word it wrote.

When a run ends, a done flag rises. A sticky error flag shows whether any word read back did not match. Each run uses a fresh address window and continues the data pattern, so back-to-back runs never reuse stale data.

Top module: `mem_port_traffic_gen`

## Requirements
- R1: `cmd_en` and `wr_en` stay low while `calib_done` is low. A `trig` pulse that arrives while `calib_done` is low starts nothing.
- R2: A `trig` pulse while idle with `calib_done` high starts exactly one run. A run is one write command followed by one read command. A `trig` that arrives during a run is ignored.
- R3: A run loads BURST_WORDS words. A word counts as accepted on a rising edge where `wr_en` is high and `wr_full` is low. The words hold a 64-bit counter that starts at 0 after reset, rises by one per accepted word and carries on across runs. `wr_mask` is all zeros whenever `wr_en` is high.
- R4: The write command is pushed only after all words of the burst have been accepted. The read command follows it. The instruction code is 3 bits: bit 0 is 1 for read and 0 for write, bit 1 equals AUTO_PRECHARGE (0 by default), and bit 2 (refresh) is 0. So the default codes are 000 for write and 001 for read.
- R5: `cmd_bl` carries BURST_WORDS-1. Both commands of a run carry the same byte address, and its low 3 bits are zero. The first run after reset uses START_ADDR with its low 3 bits cleared. Each later run adds BURST_WORDS*8.
- R6: `cmd_en` is high only while `cmd_full` is low, for one clock per command. `rd_en` is high only while `rd_empty` is low. `rd_data` is taken as valid whenever `rd_empty` is low (show-ahead).
- R7: Each word popped is compared with the word written at the same burst position. A mismatch sets `error`, which stays set until reset.
- R8: `done` rises in the clock after the last word of the burst is popped. It stays high until the next accepted trigger clears it.
- R9: After reset, `cmd_en`, `wr_en`, `rd_en`, `done` and `error` are low. The data pattern and the address restart from their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| calib_done | input | 1 | Controller calibration complete |
| trig | input | 1 | Start pulse for a self-test run |
| cmd_en | output | 1 | Push a command into the command queue |
| cmd_instr | output | 3 | Command code (bit0 read, bit1 auto-precharge, bit2 refresh) |
| cmd_bl | output | 6 | Burst length minus one |
| cmd_byte_addr | output | ADDR_W | Byte start address, aligned to the port width |
| cmd_full | input | 1 | Command queue full |
| wr_en | output | 1 | Write-data push request |
| wr_mask | output | DATA_W/8 | Byte mask, all zero |
| wr_data | output | DATA_W | Write-data word |
| wr_full | input | 1 | Write-data queue full |
| rd_en | output | 1 | Pop one read-data word |
| rd_data | input | DATA_W | Read-data word at the head of the queue |
| rd_empty | input | 1 | Read-data queue empty |
| done | output | 1 | Run finished |
| error | output | 1 | Sticky read-back mismatch |

## Verification
Runs are tried in several conditions, and each one isolates a different behaviour:
- A clean run with no backpressure checks the basic ordering: burst, then write command, then read command, then drain.
- Runs with the write and command queues intermittently full show whether acceptance honours the full flags without skipping or repeating a pattern word. These runs also carry a stray trigger mid-run, which separates a correct single-run launch from a restart.
- A run with the read queue intermittently empty exposes pops taken against an empty queue.
- A run with one corrupted word checks the compare path. A clean run after it shows that the error flag is sticky.
- A reset after several runs, followed by another run, shows that the pattern and the address restart.

// File: rtl/mem_port_traffic_gen.sv
module mem_port_traffic_gen #(
  parameter int          DATA_W         = 64,
  parameter int          BURST_WORDS    = 16,
  parameter int          ADDR_W         = 30,
  parameter int unsigned START_ADDR     = 32'h0000_014C,
  parameter bit          AUTO_PRECHARGE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  calib_done,
  input  logic                  trig,
  output logic                  cmd_en,
  output logic [2:0]            cmd_instr,
  output logic [5:0]            cmd_bl,
  output logic [ADDR_W-1:0]     cmd_byte_addr,
  input  logic                  cmd_full,
  output logic                  wr_en,
  output logic [DATA_W/8-1:0]   wr_mask,
  output logic [DATA_W-1:0]     wr_data,
  input  logic                  wr_full,
  output logic                  rd_en,
  input  logic [DATA_W-1:0]     rd_data,
  input  logic                  rd_empty,
  output logic                  done,
  output logic                  error
);
  localparam int MASK_W = DATA_W / 8;
  localparam int LSB    = $clog2(MASK_W);
  localparam int CW     = $clog2(BURST_WORDS) + 1;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(START_ADDR) & ~ADDR_W'(MASK_W - 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_WORDS * MASK_W);

  typedef enum logic [2:0] {IDLE, FILL, WCMD, RCMD, DRAIN} st_t;

  st_t               st;
  logic [CW-1:0]     idx;
  logic [DATA_W-1:0] wpat, rpat;
  logic [ADDR_W-1:0] addr;

  wire last  = idx == CW'(BURST_WORDS - 1);
  wire wr_go = wr_en && !wr_full;

  assign wr_en         = st == FILL;
  assign wr_data       = wpat;
  assign wr_mask       = '0;
  assign cmd_en        = (st == WCMD || st == RCMD) && !cmd_full;
  assign cmd_instr     = {1'b0, AUTO_PRECHARGE, st == RCMD};
  assign cmd_bl        = 6'(BURST_WORDS - 1);
  assign cmd_byte_addr = addr;
  assign rd_en         = st == DRAIN && !rd_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      idx   <= '0;
      wpat  <= '0;
      rpat  <= '0;
      addr  <= BASE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      case (st)
        IDLE: if (trig && calib_done) begin
          st   <= FILL;
          idx  <= '0;
          done <= 1'b0;
        end
        FILL: if (wr_go) begin
          wpat <= wpat + 1'b1;
          idx  <= last ? '0 : idx + 1'b1;
          if (last) st <= WCMD;
        end
        WCMD: if (cmd_en) st <= RCMD;
        RCMD: if (cmd_en) st <= DRAIN;
        DRAIN: if (rd_en) begin
          rpat <= rpat + 1'b1;
          if (rd_data != rpat) error <= 1'b1;
          idx <= last ? '0 : idx + 1'b1;
          if (last) begin
            st   <= IDLE;
            done <= 1'b1;
            addr <= addr + STEP;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R1
  calib_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en || wr_en) |-> calib_done);

  // R2
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> !done);

  // R4
  single_write_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_instr[0]) |=> !(cmd_en && !cmd_instr[0]));

  // R5
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |-> cmd_byte_addr[LSB-1:0] == '0);

  // R7
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  // R8
  done_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_en));
endmodule

// File: tb/test_mem_port_traffic_gen.sv
`timescale 1ns/1ps
module test_mem_port_traffic_gen;
  localparam int DW = 64;
  localparam int BW = 16;
  localparam int AW = 30;
  localparam int unsigned START = 32'h0000_014C;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n, calib_done, trig, cmd_full, wr_full, rd_empty;
  logic [DW-1:0] rd_data;
  logic cmd_en, wr_en, rd_en, done, error;
  logic [2:0] cmd_instr;
  logic [5:0] cmd_bl;
  logic [AW-1:0] cmd_byte_addr;
  logic [DW/8-1:0] wr_mask;
  logic [DW-1:0] wr_data;

  always #4 clk = ~clk;

  mem_port_traffic_gen #(.DATA_W(DW), .BURST_WORDS(BW), .ADDR_W(AW), .START_ADDR(START))
    i_mem_port_traffic_gen (
      .clk(clk), .rst_n(rst_n), .calib_done(calib_done), .trig(trig),
      .cmd_en(cmd_en), .cmd_instr(cmd_instr), .cmd_bl(cmd_bl), .cmd_byte_addr(cmd_byte_addr),
      .cmd_full(cmd_full), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
      .wr_full(wr_full), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
      .done(done), .error(error));

  int checks = 0, fails = 0, cyc = 0;
  int wcmds = 0, rcmds = 0, pushes = 0, pops = 0, pop_cyc = 0;
  bit stall_wr = 0, stall_cmd = 0, stall_rd = 0, corrupt = 0, exp_err = 0, wr_pending = 0;
  logic [DW-1:0] exp_wpat = '0;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] wrq[$];
  logic [DW-1:0] rdq[$];
  logic [DW-1:0] mem[int];

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc >= LIMIT) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    wr_full  = stall_wr && (cyc % 3 != 0);
    cmd_full = stall_cmd && (cyc % 4 != 0);
    rd_empty = (rdq.size() == 0) || (stall_rd && cyc % 2 == 1);
    rd_data  = (rdq.size() != 0) ? rdq[0] : '0;
    #1;
    if (wr_en || cmd_en) chk(calib_done, "R1", "push before calibration", 0, 1);
    if (wr_en && !wr_full) begin
      pushes++;
      chk(wr_data == exp_wpat, "R3", "write word", wr_data, exp_wpat);
      chk(wr_mask == '0, "R3", "byte mask", DW'(wr_mask), 0);
      wrq.push_back(wr_data);
      exp_wpat++;
    end
    if (cmd_en) begin
      chk(!cmd_full, "R6", "command while full", DW'(cmd_full), 0);
      chk(cmd_bl == 6'(BW - 1), "R5", "burst length", DW'(cmd_bl), DW'(BW - 1));
      chk(cmd_byte_addr == exp_addr, "R5", "byte address", DW'(cmd_byte_addr), DW'(exp_addr));
      if (cmd_instr == 3'b000) begin
        wcmds++;
        chk(wrq.size() == BW, "R4", "words queued at write command", DW'(wrq.size()), DW'(BW));
        chk(!wr_pending, "R4", "second write before read", DW'(wr_pending), 0);
        for (int i = 0; i < BW; i++)
          if (wrq.size() != 0) mem[int'(cmd_byte_addr >> 3) + i] = wrq.pop_front();
        wr_pending = 1;
      end else if (cmd_instr == 3'b001) begin
        rcmds++;
        chk(wr_pending, "R4", "read without write", DW'(wr_pending), 1);
        wr_pending = 0;
        for (int i = 0; i < BW; i++) begin
          logic [DW-1:0] w;
          w = mem.exists(int'(cmd_byte_addr >> 3) + i) ? mem[int'(cmd_byte_addr >> 3) + i] : '0;
          if (corrupt && i == 5) begin w = w ^ 64'h1; corrupt = 0; exp_err = 1; end
          rdq.push_back(w);
        end
        exp_addr = exp_addr + AW'(BW * 8);
      end else chk(0, "R4", "instruction code", DW'(cmd_instr), 0);
    end
    if (rd_en) begin
      chk(!rd_empty, "R6", "pop while empty", DW'(rd_empty), 0);
      if (!rd_empty && rdq.size() != 0) begin void'(rdq.pop_front()); pops++; pop_cyc = cyc; end
    end
  endtask

  task automatic run(bit mid_trig);
    int w0, r0, p0;
    w0 = wcmds; r0 = rcmds; p0 = pops;
    trig = 1; step(); trig = 0;
    step();
    chk(done == 0, "R8", "done cleared at start", DW'(done), 0);
    for (int k = 0; k < 4; k++) step();
    if (mid_trig) begin trig = 1; step(); trig = 0; end
    while (!done) step();
    chk(cyc == pop_cyc + 1, "R8", "done timing", DW'(cyc), DW'(pop_cyc + 1));
    chk(pops - p0 == BW, "R6", "words drained", DW'(pops - p0), DW'(BW));
    chk(error == exp_err, "R7", "error flag", DW'(error), DW'(exp_err));
    repeat (6) step();
    chk(wcmds == w0 + 1 && rcmds == r0 + 1, "R2", "commands per trigger",
        DW'(wcmds - w0 + rcmds - r0), 2);
    chk(done == 1, "R8", "done held", DW'(done), 1);
  endtask

  initial begin
    rst_n = 0; calib_done = 0; trig = 0; cmd_full = 0; wr_full = 0; rd_empty = 1; rd_data = '0;
    exp_addr = AW'(START) & ~AW'(7);
    repeat (3) step();
    chk(!cmd_en && !wr_en && !rd_en && !done && !error, "R9", "outputs in reset",
        {cmd_en, wr_en, rd_en, done, error}, 0);
    rst_n = 1;
    step();
    chk(!cmd_en && !wr_en && !rd_en && !done && !error, "R9", "outputs after reset",
        {cmd_en, wr_en, rd_en, done, error}, 0);
    trig = 1; step(); trig = 0;
    repeat (12) step();
    chk(pushes == 0 && wcmds == 0 && rcmds == 0, "R1", "trigger before calibration",
        DW'(pushes + wcmds + rcmds), 0);
    chk(done == 0, "R1", "no run before calibration", DW'(done), 0);
    calib_done = 1;
    repeat (3) step();
    run(0);
    stall_wr = 1; stall_cmd = 1; run(1);
    stall_wr = 0; stall_cmd = 0; stall_rd = 1; run(0);
    stall_rd = 0; corrupt = 1; run(0);
    stall_wr = 1; stall_cmd = 1; stall_rd = 1; run(1);
    chk(error == 1, "R7", "error sticky over clean run", DW'(error), 1);
    stall_wr = 0; stall_cmd = 0; stall_rd = 0;
    rst_n = 0; step(); step();
    chk(!done && !error, "R9", "flags cleared by reset", {done, error}, 0);
    rst_n = 1; exp_err = 0; exp_wpat = '0; exp_addr = AW'(START) & ~AW'(7);
    wrq.delete(); rdq.delete(); wr_pending = 0;
    repeat (2) step();
    run(0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule